// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block handles the modem handshake side of a UART. It holds a small control register. The register drives two external handshake outputs: terminal-ready and request-to-send. It also holds two auxiliary control bits that stay inside the block, a loop-test enable and the modem-status interrupt enable. The block samples four handshake inputs: clear-to-send, data-set-ready, carrier-detect and ring. Each input passes through a synchronizer. The block then watches each input for transitions and latches them as sticky change flags until software reads the status port.

A change in either direction on clear-to-send, data-set-ready or carrier-detect sets that input's flag. For ring, only the falling (trailing) edge counts. An interrupt request is raised while any flag is set and the enable bit is on. In loop-test mode the control bits are fed back internally onto the four status inputs. The external outputs are forced low and the external inputs are ignored, so software can exercise the whole detection path without a modem attached.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, both handshake outputs are 0, the interrupt request is 0 and the status read data is 0x00.
- R2: With loop-test off, term_ready_o follows control bit 0 and req_send_o follows control bit 1, one clock after a control write.
- R3: Any transition, rising or falling, on cts_i, dsr_i or dcd_i sets its change flag. Flag positions in the status read data are: bit 0 clear-to-send, bit 1 data-set-ready, bit 3 carrier-detect.
- R4: On ri_i, a falling transition sets the ring flag (status bit 2). A rising transition leaves that flag unchanged.
- R5: The status read data carries the synchronized input levels in bits 7:4 and the change flags in bits 3:0. Level positions are: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring, bit 7 carrier-detect. A clock with msr_rd high clears all change flags.
- R6: A transition detected in the same clock as a status read sets its flag after the clear, so it shows on the next read.
- R7: irq_o is high exactly when at least one change flag is set and the interrupt enable (control bit 5) is 1.
- R8: With loop-test on (control bit 4), both external outputs are 0 and the external inputs are ignored. The status inputs are then driven internally: request-to-send drives clear-to-send, terminal-ready drives data-set-ready, auxiliary bit 2 drives ring, and auxiliary bit 3 drives carrier-detect.
- R9: A change flag stays set until a status read, even after its input returns to its earlier level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 6 | Control value: bit0 terminal-ready, bit1 request-to-send, bit2 aux1, bit3 aux2, bit4 loop-test, bit5 interrupt enable |
| msr_rd | input | 1 | Status read strobe; clears the change flags at the clock edge |
| msr_rdata | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| ri_i | input | 1 | Ring input, asynchronous |
| term_ready_o | output | 1 | Terminal-ready output |
| req_send_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A status read can clear the flags in the very clock in which the edge detector reports a new transition. The two operations then compete for the same flag bit. The bench provokes this case by raising carrier-detect and then asserting the read strobe exactly two clocks later, when the synchronized level has just changed. It expects that read to show the new level with the flag still clear. It expects the read after it to show the flag set, and a third read to show it cleared.

// File: rtl/uart_modem_pkg.sv
// Package: shared constants and the control register layout for the
// modem handshake block. Assumes four status lines in a fixed index order.
package uart_modem_pkg;
    localparam int NUM_STAT   = 4;
    localparam int CTL_W      = 6;
    localparam int RDATA_W    = 2 * NUM_STAT;
    // Status line index order; the read data layout depends on it.
    localparam int IDX_CTS    = 0;
    localparam int IDX_DSR    = 1;
    localparam int IDX_RI     = 2;
    localparam int IDX_DCD    = 3;
    // Lines that only count a falling (trailing) transition.
    localparam logic [NUM_STAT-1:0] TRAIL_ONLY = 4'b0100;

    typedef struct packed {
        logic irq_en;
        logic loop_en;
        logic aux2;
        logic aux1;
        logic req_send;
        logic term_ready;
    } modem_ctl_t;
endpackage

// File: rtl/modem_ctl_reg.sv
// modem_ctl_reg: holds the control register, drives the two external
// handshake pins (forced low in loop-test) and builds the internal
// loopback vector in status index order. Assumes a single write strobe.
module modem_ctl_reg
    import uart_modem_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [CTL_W-1:0]    wdata,
    output modem_ctl_t          ctl_q,
    output logic                term_ready_o,
    output logic                req_send_o,
    output logic [NUM_STAT-1:0] loop_src
);
    // Control register capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= modem_ctl_t'(wdata);
        end
    end

    // External pins, held inactive during loop-test.
    always_comb begin
        term_ready_o = ctl_q.term_ready & ~ctl_q.loop_en;
        req_send_o   = ctl_q.req_send   & ~ctl_q.loop_en;
    end

    // Loopback routing of control bits onto the status indices.
    always_comb begin
        loop_src           = '0;
        loop_src[IDX_CTS]  = ctl_q.req_send;
        loop_src[IDX_DSR]  = ctl_q.term_ready;
        loop_src[IDX_RI]   = ctl_q.aux1;
        loop_src[IDX_DCD]  = ctl_q.aux2;
    end
endmodule

// File: rtl/modem_sync.sv
// modem_sync: multi-stage flop synchronizer, one chain per bit.
// Assumes STAGES >= 2; the last stage is the stable level.
module modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    // Remaining stages shift the sampled value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/modem_change_det.sv
// modem_change_det: remembers the previous synchronized level of every
// line and reports a one-cycle event on a transition. Lines marked in
// TRAIL_MASK report only a 1-to-0 transition.
module modem_change_det #(
    parameter int               WIDTH      = 4,
    parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev_q;

    // Previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Per-line event decode, trailing-only or any-change.
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (TRAIL_MASK[i]) begin : g_trail
            assign evt[i] = prev_q[i] & ~lvl[i];
        end else begin : g_any
            assign evt[i] = prev_q[i] ^ lvl[i];
        end
    end
endmodule

// File: rtl/modem_flags.sv
// modem_flags: sticky change flags. A read clears them; an event in the
// same cycle wins over the clear so it is never lost.
module modem_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] evt,
    output logic [WIDTH-1:0] flags
);
    // Flag update: clear on read, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | evt;
    end
endmodule

// File: rtl/uart_modem_ctl.sv
// uart_modem_ctl: modem handshake control and status for a UART.
// Drives two handshake pins and samples four asynchronous status lines,
// with loop-test and a modem-status interrupt request.
// Assumes msr_rd is a single-cycle strobe from the register decode.
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic [5:0]   ctl_wdata,
    input  logic         msr_rd,
    output logic [7:0]   msr_rdata,
    input  logic         cts_i,
    input  logic         dsr_i,
    input  logic         dcd_i,
    input  logic         ri_i,
    output logic         term_ready_o,
    output logic         req_send_o,
    output logic         irq_o
);
    modem_ctl_t          ctl_q;
    logic [NUM_STAT-1:0] loop_src;
    logic [NUM_STAT-1:0] ext_raw;
    logic [NUM_STAT-1:0] stat_raw;
    logic [NUM_STAT-1:0] stat_lvl;
    logic [NUM_STAT-1:0] stat_evt;
    logic [NUM_STAT-1:0] stat_flags;
    logic                loop_en;
    logic                irq_en;

    modem_ctl_reg u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (ctl_wr),
        .wdata        (ctl_wdata),
        .ctl_q        (ctl_q),
        .term_ready_o (term_ready_o),
        .req_send_o   (req_send_o),
        .loop_src     (loop_src)
    );

    assign loop_en = ctl_q.loop_en;
    assign irq_en  = ctl_q.irq_en;

    // Gather the external lines in status index order.
    always_comb begin
        ext_raw          = '0;
        ext_raw[IDX_CTS] = cts_i;
        ext_raw[IDX_DSR] = dsr_i;
        ext_raw[IDX_RI]  = ri_i;
        ext_raw[IDX_DCD] = dcd_i;
    end

    // Source select ahead of the synchronizer: loopback or pins.
    assign stat_raw = loop_en ? loop_src : ext_raw;

    modem_sync #(
        .WIDTH  (NUM_STAT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_raw),
        .q     (stat_lvl)
    );

    modem_change_det #(
        .WIDTH      (NUM_STAT),
        .TRAIL_MASK (TRAIL_ONLY)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stat_lvl),
        .evt   (stat_evt)
    );

    modem_flags #(
        .WIDTH (NUM_STAT)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (msr_rd),
        .evt   (stat_evt),
        .flags (stat_flags)
    );

    // Status read data: levels high nibble, flags low nibble.
    assign msr_rdata = {stat_lvl, stat_flags};

    // Interrupt request from any pending flag when enabled.
    assign irq_o = irq_en & (|stat_flags);
endmodule

// File: rtl/uart_modem_ctl_chk.sv
// uart_modem_ctl_chk: property checker bound to uart_modem_ctl.
module uart_modem_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msr_rd,
    input logic [7:0] msr_rdata,
    input logic       term_ready_o,
    input logic       req_send_o,
    input logic       irq_o,
    input logic       loop_en,
    input logic       irq_en,
    input logic [3:0] stat_evt
);
    p_loop_pins_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (!term_ready_o && !req_send_o));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && (msr_rdata[3:0] != 4'b0)));

    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0])));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && (stat_evt == 4'b0)) |=> (msr_rdata[3:0] == 4'b0));

    p_read_keeps_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && (stat_evt != 4'b0)) |=> ((msr_rdata[3:0] & $past(stat_evt)) == $past(stat_evt)));

    p_ring_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msr_rdata[6]) && !msr_rdata[2]) |=> !msr_rdata[2]);

    p_cts_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_evt[0] |=> msr_rdata[0]);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msr_rd       (msr_rd),
    .msr_rdata    (msr_rdata),
    .term_ready_o (term_ready_o),
    .req_send_o   (req_send_o),
    .irq_o        (irq_o),
    .loop_en      (loop_en),
    .irq_en       (irq_en),
    .stat_evt     (stat_evt)
);

// File: tb/uart_modem_ctl_tb.sv
// Scoreboard bench: read tasks queue expected status bytes, a monitor
// compares them at the falling edge of each read cycle.
module uart_modem_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       msr_rd = 1'b0;
    logic [7:0] msr_rdata;
    logic       cts_i = 1'b0, dsr_i = 1'b0, dcd_i = 1'b0, ri_i = 1'b0;
    logic       term_ready_o, req_send_o, irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    uart_modem_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .msr_rd(msr_rd), .msr_rdata(msr_rdata),
        .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i),
        .term_ready_o(term_ready_o), .req_send_o(req_send_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Step to 3 ns after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic settle();
        repeat (4) tick();
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    // Driver: queue the expected byte and strobe one read cycle.
    task automatic rd_status(input logic [7:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        msr_rd = 1'b1;
        tick();
        msr_rd = 1'b0;
    endtask

    // Monitor: compare read data in the middle of each read cycle.
    always @(negedge clk) begin
        if (rst_n && msr_rd) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard-empty", 8'hFF, 8'h00);
            end else begin
                chk(tag_q.pop_front(), msr_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rdata", msr_rdata, 8'h00);
        chk("R1 outputs", {6'b0, term_ready_o, req_send_o}, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2 pin follow
        wr_ctl(6'b000001);
        chk("R2 term_ready", {6'b0, term_ready_o, req_send_o}, 8'h02);
        wr_ctl(6'b000010);
        chk("R2 req_send", {6'b0, term_ready_o, req_send_o}, 8'h01);
        wr_ctl(6'b000000);

        // R3/R5 single rise then clear
        cts_i = 1'b1; settle();
        rd_status(8'h11, "R3 cts rise");
        rd_status(8'h10, "R5 read clears");

        // R3 several lines, both directions
        cts_i = 1'b0; dsr_i = 1'b1; dcd_i = 1'b1; settle();
        rd_status(8'hAB, "R3 multi change");

        // R4 ring rise ignored, fall flagged
        ri_i = 1'b1; settle();
        rd_status(8'hE0, "R4 ring rise ignored");
        ri_i = 1'b0; settle();
        rd_status(8'hA4, "R4 ring trailing");

        // R7 interrupt gating
        wr_ctl(6'b100000);
        dsr_i = 1'b0; settle();
        chk("R7 irq set", {7'b0, irq_o}, 8'h01);
        rd_status(8'h82, "R7 dsr fall");
        chk("R7 irq cleared by read", {7'b0, irq_o}, 8'h00);
        wr_ctl(6'b000000);
        dcd_i = 1'b0; settle();
        chk("R7 irq disabled", {7'b0, irq_o}, 8'h00);
        wr_ctl(6'b100000);
        chk("R7 irq enabled late", {7'b0, irq_o}, 8'h01);
        rd_status(8'h08, "R7 dcd fall");
        wr_ctl(6'b000000);

        // R9 short pulse stays flagged
        dsr_i = 1'b1; tick(); tick();
        dsr_i = 1'b0; settle();
        rd_status(8'h02, "R9 sticky pulse");

        // R6 event in the read cycle
        dcd_i = 1'b1; tick(); tick();
        rd_status(8'h80, "R6 read during event");
        rd_status(8'h88, "R6 event kept");
        rd_status(8'h80, "R6 then cleared");
        dcd_i = 1'b0; settle();
        rd_status(8'h08, "R3 dcd fall");

        // R8 loop-test
        wr_ctl(6'b011001);
        chk("R8 pins idle", {6'b0, term_ready_o, req_send_o}, 8'h00);
        settle();
        rd_status(8'hAA, "R8 loop routing");
        cts_i = 1'b1; settle();
        rd_status(8'hA0, "R8 external ignored");
        wr_ctl(6'b011101); settle();
        wr_ctl(6'b011001); settle();
        rd_status(8'hA4, "R8 aux1 to ring");
        wr_ctl(6'b000000); settle();
        rd_status(8'h1B, "R8 leave loop");
        cts_i = 1'b0; settle();
        rd_status(8'h01, "R3 cts fall");

        tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule